// File: doc/BRIEF.md
# Zero-Suppression Event Packetizer

This block takes one corrected frame of 128 channel readings per bunch crossing and turns it into a serial record of words on a valid/ready stream. A channel goes into the record only when its reading is strictly greater than a programmable threshold. Each record can start with an identification header that carries the bunch, sensor and chip numbers. A size word can follow, holding the hit count and a flag that shows hits were lost. After these come one word per kept channel, each holding the channel number and its reading.

A two-bit policy input sets when the header and size words are sent. The header can go out on every crossing with the size word only when hits exist. Both words can go out on every crossing. Or the record can be sent only when at least one hit exists. The size field width is a parameter (3 or 4 bits). The number of hit words per record saturates at a limit that this width sets, and hits past the limit are dropped. Hits leave in ascending channel order, with no reordering and no clustering.

Frames enter through a valid/ready handshake. While a record is being sent, the frame input is held not-ready. Downstream back-pressure therefore stalls the source and never drops data.

Top module: `zs_event_packer`

## Requirements
- R1: A channel is kept only when its reading is strictly greater than `i_thresh`. A reading equal to the threshold is discarded.
- R2: A hit word has `o_kind` = 2, the channel number in bits [12:6] and the reading in bits [5:0], with the upper bits zero. Hit words of one record leave in strictly ascending channel order.
- R3: A header word has `o_kind` = 0 and holds {bunch[27:16], sensor[15:8], chip[7:0]}. When a record is sent, the header is its first word. It is presented with `o_valid` high in the cycle right after the frame is accepted.
- R4: Policy 0: the header is sent for every frame. The size word is added only when at least one hit is kept.
- R5: Policy 1, and the spare code 3 treated as policy 1: the header and the size word are sent for every frame, including frames with no hits.
- R6: Policy 2: a frame with no kept hits produces no words and is consumed in one cycle, so `o_frame_ready` stays high and frames can be accepted on back-to-back cycles. A frame with hits gets a header and a size word.
- R7: A size word has `o_kind` = 1. It holds the drop flag at bit 3 and the count field in bits [2:0] (3-bit field). The hit limit is 8 for policies 0 and 2, where a count of 8 is encoded as 0. The limit is 7 for policies 1 and 3, where the count is encoded directly.
- R8: At most the limit's worth of hit words are sent, namely the lowest-numbered kept channels. The drop flag is 1 exactly when more hits were kept than the limit allows.
- R9: While `o_valid` is high and `i_out_ready` is low, `o_kind` and `o_data` hold steady, and no word is lost or repeated.
- R10: After reset `o_valid` is low and `o_frame_ready` is high. `o_frame_ready` is high only while no record is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_mode | input | 2 | Header policy, sampled at frame acceptance |
| i_thresh | input | 6 | Keep threshold, compared at frame acceptance |
| i_frame_valid | input | 1 | Frame present |
| o_frame_ready | output | 1 | Frame can be accepted |
| i_frame | input | 768 | Readings; channel c at bits [6c+5:6c] |
| i_bx_id | input | 12 | Bunch number |
| i_sensor_id | input | 8 | Sensor number |
| i_chip_id | input | 8 | Chip number |
| o_valid | output | 1 | Output word present |
| i_out_ready | input | 1 | Downstream accepts the word |
| o_kind | output | 2 | Word type: 0 header, 1 size, 2 hit |
| o_data | output | 28 | Word contents |

## Verification
The header, when one is due, must be valid in the cycle after the frame handshake, since only the state register lies in between. The bench samples on the falling edge that follows the accepting rising edge. For an empty frame under policy 2, the same sample must show no valid word and the frame input ready again. All later words depend on the back-pressure pattern, so the bench does not predict their cycle. It captures every word on the rising edge where `o_valid` and `i_out_ready` are both high, then compares the captured sequence with a record computed from the frame, once the frame input shows ready again. A directed stall holds `i_out_ready` low and checks on each falling edge that the header word stays unchanged and no second frame is taken.

// File: rtl/zsp_pkg.sv
// Shared types of the zero-suppression event packetizer.
// Assumes: the output word kind is 2 bits wide and the header policy is a 2-bit code.
package zsp_pkg;

    typedef enum logic [1:0] {
        KIND_HDR  = 2'd0,
        KIND_SIZE = 2'd1,
        KIND_HIT  = 2'd2
    } word_kind_e;

    typedef enum logic [1:0] {
        MODE_HDR_ALWAYS = 2'd0,
        MODE_ALL_ALWAYS = 2'd1,
        MODE_ONLY_HITS  = 2'd2,
        MODE_SPARE      = 2'd3
    } hdr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_SIZE = 2'd2,
        ST_HITS = 2'd3
    } pk_state_e;

endpackage

// File: rtl/zsp_thresh_mask.sv
// Per-channel threshold comparison.
// Channel c sits at bits [c*ADC_W +: ADC_W] of the frame. A channel is flagged
// when its reading is strictly greater than the threshold. Purely combinational.
module zsp_thresh_mask #(
    parameter int N_CH  = 128,
    parameter int ADC_W = 6
) (
    input  logic [N_CH*ADC_W-1:0] i_frame,
    input  logic [ADC_W-1:0]      i_thresh,
    output logic [N_CH-1:0]       o_mask
);

    // one comparator for each channel
    for (genvar g = 0; g < N_CH; g++) begin : g_cmp
        assign o_mask[g] = i_frame[g*ADC_W +: ADC_W] > i_thresh;
    end

endmodule

// File: rtl/zsp_popcount.sv
// Counts the set bits of a mask. Purely combinational.
// Assumes CNT_W is wide enough to hold N_BITS.
module zsp_popcount #(
    parameter int N_BITS = 128,
    parameter int CNT_W  = $clog2(N_BITS + 1)
) (
    input  logic [N_BITS-1:0] i_bits,
    output logic [CNT_W-1:0]  o_count
);

    // adder chain over all mask bits
    always_comb begin
        o_count = '0;
        for (int i = 0; i < N_BITS; i++) begin
            o_count = o_count + CNT_W'(i_bits[i]);
        end
    end

endmodule

// File: rtl/zsp_first_set.sv
// Index of the lowest set bit of a mask. The result is 0 when the mask is empty,
// so the caller must qualify it. Purely combinational.
module zsp_first_set #(
    parameter int N_BITS = 128,
    parameter int IDX_W  = $clog2(N_BITS)
) (
    input  logic [N_BITS-1:0] i_bits,
    output logic [IDX_W-1:0]  o_index
);

    // scan from the top so that the lowest set bit wins
    always_comb begin
        o_index = '0;
        for (int i = N_BITS - 1; i >= 0; i--) begin
            if (i_bits[i]) o_index = IDX_W'(i);
        end
    end

endmodule

// File: rtl/zs_event_packer.sv
// Zero-suppression event packetizer.
// Accepts one frame when idle. It keeps the channels above threshold and then
// sends header, size and hit words according to the policy latched at acceptance.
// Assumes: the header is the widest word; the frame input stays not-ready for the
// whole record; hit words leave lowest channel first.
module zs_event_packer
    import zsp_pkg::*;
#(
    parameter int N_CH     = 128,
    parameter int ADC_W    = 6,
    parameter int PSIZE_W  = 3,
    parameter int BX_W     = 12,
    parameter int SENSOR_W = 8,
    parameter int CHIP_W   = 8,
    localparam int CH_W    = $clog2(N_CH),
    localparam int HDR_W   = BX_W + SENSOR_W + CHIP_W,
    localparam int HIT_W   = CH_W + ADC_W,
    localparam int OUT_A   = (HDR_W > HIT_W) ? HDR_W : HIT_W,
    localparam int OUT_W   = (OUT_A > PSIZE_W + 1) ? OUT_A : PSIZE_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              i_mode,
    input  logic [ADC_W-1:0]        i_thresh,
    input  logic                    i_frame_valid,
    output logic                    o_frame_ready,
    input  logic [N_CH*ADC_W-1:0]   i_frame,
    input  logic [BX_W-1:0]         i_bx_id,
    input  logic [SENSOR_W-1:0]     i_sensor_id,
    input  logic [CHIP_W-1:0]       i_chip_id,
    output logic                    o_valid,
    input  logic                    i_out_ready,
    output logic [1:0]              o_kind,
    output logic [OUT_W-1:0]        o_data
);

    localparam int CNT_W = $clog2(N_CH + 1);
    localparam int LIM_W = PSIZE_W + 1;
    localparam logic [LIM_W-1:0] LIM_FULL  = LIM_W'(1) << PSIZE_W;
    localparam logic [LIM_W-1:0] LIM_SHORT = LIM_FULL - LIM_W'(1);

    pk_state_e              state_q;
    hdr_mode_e              mode_q;
    logic [N_CH-1:0]        mask_q;
    logic [N_CH*ADC_W-1:0]  adc_q;
    logic [HDR_W-1:0]       hdr_q;
    logic [CNT_W-1:0]       count_q;
    logic [LIM_W-1:0]       sent_q;

    logic [N_CH-1:0]        new_mask;
    logic [CNT_W-1:0]       new_count;
    logic [CH_W-1:0]        hit_idx;
    logic [N_CH-1:0]        rem_mask;
    logic [LIM_W-1:0]       limit;
    logic                   has_hits;
    logic                   dropped;
    logic [PSIZE_W-1:0]     size_field;
    logic                   accept;
    logic                   word_taken;
    hdr_mode_e              mode_in;

    zsp_thresh_mask #(.N_CH(N_CH), .ADC_W(ADC_W)) u_mask (
        .i_frame  (i_frame),
        .i_thresh (i_thresh),
        .o_mask   (new_mask)
    );

    zsp_popcount #(.N_BITS(N_CH), .CNT_W(CNT_W)) u_count (
        .i_bits  (new_mask),
        .o_count (new_count)
    );

    zsp_first_set #(.N_BITS(N_CH), .IDX_W(CH_W)) u_first (
        .i_bits  (mask_q),
        .o_index (hit_idx)
    );

    assign o_frame_ready = (state_q == ST_IDLE);
    assign accept        = i_frame_valid && o_frame_ready;
    assign o_valid       = (state_q != ST_IDLE);
    assign word_taken    = o_valid && i_out_ready;
    assign mode_in       = (hdr_mode_e'(i_mode) == MODE_SPARE) ? MODE_ALL_ALWAYS
                                                               : hdr_mode_e'(i_mode);

    // hit limit, drop flag and encoded size field of the latched frame
    always_comb begin
        limit      = (mode_q == MODE_ALL_ALWAYS) ? LIM_SHORT : LIM_FULL;
        has_hits   = (count_q != '0);
        dropped    = count_q > CNT_W'(limit);
        size_field = (count_q >= CNT_W'(limit)) ? limit[PSIZE_W-1:0]
                                                : count_q[PSIZE_W-1:0];
    end

    // remaining hits once the current lowest one has gone out
    always_comb begin
        rem_mask          = mask_q;
        rem_mask[hit_idx] = 1'b0;
    end

    // output word multiplexer
    always_comb begin
        o_kind = KIND_HDR;
        o_data = '0;
        case (state_q)
            ST_HDR: begin
                o_kind = KIND_HDR;
                o_data = OUT_W'(hdr_q);
            end
            ST_SIZE: begin
                o_kind = KIND_SIZE;
                o_data = OUT_W'({dropped, size_field});
            end
            ST_HITS: begin
                o_kind = KIND_HIT;
                o_data = OUT_W'({hit_idx, adc_q[int'(hit_idx)*ADC_W +: ADC_W]});
            end
            default: begin
                o_kind = KIND_HDR;
                o_data = '0;
            end
        endcase
    end

    // record sequencer and frame capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_HDR_ALWAYS;
            mask_q  <= '0;
            adc_q   <= '0;
            hdr_q   <= '0;
            count_q <= '0;
            sent_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q  <= mode_in;
                        mask_q  <= new_mask;
                        adc_q   <= i_frame;
                        hdr_q   <= {i_bx_id, i_sensor_id, i_chip_id};
                        count_q <= new_count;
                        if (mode_in == MODE_ONLY_HITS && new_count == '0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_HDR;
                        end
                    end
                end
                ST_HDR: begin
                    if (word_taken) begin
                        if (mode_q == MODE_HDR_ALWAYS && !has_hits) state_q <= ST_IDLE;
                        else                                        state_q <= ST_SIZE;
                    end
                end
                ST_SIZE: begin
                    if (word_taken) begin
                        sent_q  <= '0;
                        state_q <= has_hits ? ST_HITS : ST_IDLE;
                    end
                end
                ST_HITS: begin
                    if (word_taken) begin
                        mask_q <= rem_mask;
                        sent_q <= sent_q + LIM_W'(1);
                        if (rem_mask == '0 || sent_q + LIM_W'(1) == limit) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/zsp_chk.sv
// Protocol checker for zs_event_packer, attached by bind.
// It watches only the block's ports and keeps its own record-level bookkeeping.
module zsp_chk
    import zsp_pkg::*;
#(
    parameter int PSIZE_W = 3,
    parameter int CH_W    = 7,
    parameter int ADC_W   = 6,
    parameter int OUT_W   = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i_frame_valid,
    input logic             o_frame_ready,
    input logic             o_valid,
    input logic             i_out_ready,
    input logic [1:0]       o_kind,
    input logic [OUT_W-1:0] o_data
);

    localparam int HC_W = PSIZE_W + 2;

    logic [HC_W-1:0] hit_cnt;
    logic [CH_W-1:0] last_ch;
    logic            have_last;
    logic [1:0]      last_kind;
    logic            taken;

    assign taken = o_valid && i_out_ready;

    // per-record hit count, last channel and last word kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt   <= '0;
            last_ch   <= '0;
            have_last <= 1'b0;
            last_kind <= KIND_HIT;
        end else if (taken) begin
            last_kind <= o_kind;
            if (o_kind == KIND_HDR) begin
                hit_cnt   <= '0;
                have_last <= 1'b0;
            end else if (o_kind == KIND_HIT) begin
                hit_cnt   <= hit_cnt + HC_W'(1);
                have_last <= 1'b1;
                last_ch   <= o_data[ADC_W +: CH_W];
            end
        end
    end

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !i_out_ready) |=> (o_valid && $stable(o_kind) && $stable(o_data))); // R9

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> !o_frame_ready); // R10

    AST_HDR_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (i_frame_valid && o_frame_ready) |=> (!o_valid || o_kind == KIND_HDR)); // R3

    AST_HIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_kind == KIND_HIT) |-> (hit_cnt < (HC_W'(1) << PSIZE_W))); // R8

    AST_HIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_kind == KIND_HIT && have_last) |-> (o_data[ADC_W +: CH_W] > last_ch)); // R2

    AST_SIZE_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_kind == KIND_SIZE) |-> (last_kind == KIND_HDR)); // R4

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> (o_kind != 2'd3)); // R2

endmodule

bind zs_event_packer zsp_chk #(
    .PSIZE_W (PSIZE_W),
    .CH_W    (CH_W),
    .ADC_W   (ADC_W),
    .OUT_W   (OUT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .i_frame_valid (i_frame_valid),
    .o_frame_ready (o_frame_ready),
    .o_valid       (o_valid),
    .i_out_ready   (i_out_ready),
    .o_kind        (o_kind),
    .o_data        (o_data)
);

// File: tb/zs_event_packer_tb.sv
`timescale 1ns/1ps
// Bench for zs_event_packer: a vector table walked by one loop, then directed tests.
module zs_event_packer_tb_top;

    localparam int N_CH    = 128;
    localparam int ADC_W   = 6;
    localparam int PSIZE_W = 3;
    localparam int FR_W    = N_CH * ADC_W;
    localparam int OUT_W   = 28;
    localparam int CAP_N   = 1024;

    typedef struct packed {
        logic [1:0] mode;
        logic [5:0] thr;
        logic [6:0] first;
        logic [6:0] stride;
        logic [7:0] nplace;
        logic       bp;
    } vec_t;

    localparam int N_VEC = 13;
    localparam vec_t VECS [N_VEC] = '{
        '{2'd0, 6'd3,  7'd5,   7'd20, 8'd3,   1'b0},
        '{2'd1, 6'd3,  7'd0,   7'd1,  8'd0,   1'b0},
        '{2'd0, 6'd3,  7'd0,   7'd1,  8'd0,   1'b0},
        '{2'd2, 6'd3,  7'd0,   7'd1,  8'd0,   1'b0},
        '{2'd2, 6'd10, 7'd127, 7'd1,  8'd1,   1'b1},
        '{2'd1, 6'd3,  7'd0,   7'd16, 8'd7,   1'b0},
        '{2'd1, 6'd3,  7'd0,   7'd16, 8'd8,   1'b1},
        '{2'd0, 6'd3,  7'd0,   7'd16, 8'd8,   1'b0},
        '{2'd2, 6'd3,  7'd3,   7'd14, 8'd9,   1'b1},
        '{2'd3, 6'd3,  7'd1,   7'd50, 8'd2,   1'b0},
        '{2'd0, 6'd0,  7'd0,   7'd1,  8'd128, 1'b1},
        '{2'd2, 6'd62, 7'd64,  7'd1,  8'd4,   1'b1},
        '{2'd1, 6'd63, 7'd0,   7'd1,  8'd0,   1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       i_mode = '0;
    logic [5:0]       i_thresh = '0;
    logic             i_frame_valid = 1'b0;
    logic             o_frame_ready;
    logic [FR_W-1:0]  i_frame = '0;
    logic [11:0]      i_bx_id = '0;
    logic [7:0]       i_sensor_id = '0;
    logic [7:0]       i_chip_id = '0;
    logic             o_valid;
    logic             i_out_ready = 1'b1;
    logic [1:0]       o_kind;
    logic [OUT_W-1:0] o_data;

    int checks = 0;
    int failures = 0;
    logic bp_en = 1'b0;
    logic hold = 1'b0;
    logic [7:0] lfsr = 8'h5A;

    logic [1:0]       cap_kind [0:CAP_N-1];
    logic [OUT_W-1:0] cap_data [0:CAP_N-1];
    int cap_n = 0;

    always #4 clk = ~clk;

    zs_event_packer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .i_mode        (i_mode),
        .i_thresh      (i_thresh),
        .i_frame_valid (i_frame_valid),
        .o_frame_ready (o_frame_ready),
        .i_frame       (i_frame),
        .i_bx_id       (i_bx_id),
        .i_sensor_id   (i_sensor_id),
        .i_chip_id     (i_chip_id),
        .o_valid       (o_valid),
        .i_out_ready   (i_out_ready),
        .o_kind        (o_kind),
        .o_data        (o_data)
    );

    // word capture on every accepted output handshake
    always @(posedge clk) begin
        if (rst_n && o_valid && i_out_ready && cap_n < CAP_N) begin
            cap_kind[cap_n] <= o_kind;
            cap_data[cap_n] <= o_data;
            cap_n <= cap_n + 1;
        end
    end

    // downstream ready pattern
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            i_out_ready = hold ? 1'b0 : (bp_en ? (lfsr[0] | lfsr[2]) : 1'b1);
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic build_frame(input vec_t v, output logic [FR_W-1:0] frm);
        int ch;
        int val;
        for (int c = 0; c < N_CH; c++) frm[c*ADC_W +: ADC_W] = ADC_W'(v.thr);
        if (v.thr < 63) begin
            for (int k = 0; k < int'(v.nplace); k++) begin
                ch  = (int'(v.first) + k * int'(v.stride)) % N_CH;
                val = int'(v.thr) + 1 + (k % (63 - int'(v.thr)));
                frm[ch*ADC_W +: ADC_W] = ADC_W'(val);
            end
        end
    endtask

    // send one frame and compare the captured record with the computed one
    task automatic run_frame(input vec_t v, input logic [FR_W-1:0] frm,
                             input int vi, input bit stall);
        logic [1:0]       ek [0:31];
        logic [OUT_W-1:0] ed [0:31];
        logic [OUT_W-1:0] held;
        int total;
        int limit;
        int emit;
        int field;
        int sat;
        int n_exp;
        int base;
        int m;
        logic [11:0] bx;
        logic [7:0]  sid;
        logic [7:0]  cid;
        bx  = 12'(100 + vi * 37);
        sid = 8'(vi + 3);
        cid = 8'hA0 ^ 8'(vi);
        m   = int'(v.mode);
        total = 0;
        for (int c = 0; c < N_CH; c++) if (frm[c*ADC_W +: ADC_W] > v.thr) total++;
        limit = (m == 1 || m == 3) ? 7 : 8;
        emit  = (total > limit) ? limit : total;
        sat   = (total > limit) ? 1 : 0;
        field = (emit == limit) ? (limit % 8) : emit;
        n_exp = 0;
        if (!(m == 2 && total == 0)) begin
            ek[n_exp] = 2'd0; ed[n_exp] = OUT_W'({bx, sid, cid}); n_exp++;
        end
        if (m == 1 || m == 3 || total > 0) begin
            ek[n_exp] = 2'd1; ed[n_exp] = OUT_W'(sat * 8 + field); n_exp++;
        end
        for (int c = 0, e = 0; c < N_CH && e < emit; c++) begin
            if (frm[c*ADC_W +: ADC_W] > v.thr) begin
                ek[n_exp] = 2'd2;
                ed[n_exp] = OUT_W'({7'(c), frm[c*ADC_W +: ADC_W]});
                n_exp++;
                e++;
            end
        end

        bp_en = v.bp;
        if (stall) begin
            hold = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        while (!o_frame_ready) @(negedge clk);
        base = cap_n;
        i_mode = v.mode; i_thresh = v.thr; i_frame = frm;
        i_bx_id = bx; i_sensor_id = sid; i_chip_id = cid;
        i_frame_valid = 1'b1;
        @(negedge clk);
        i_frame_valid = 1'b0;
        // header is due one cycle after acceptance
        if (n_exp > 0) begin
            chk(o_valid && o_kind == 2'd0, $sformatf("R3 header latency vec %0d", vi),
                {o_valid, o_kind}, 3'b100);
        end else begin
            chk(!o_valid && o_frame_ready, $sformatf("R6 empty frame silent vec %0d", vi),
                {o_valid, o_frame_ready}, 2'b01);
        end
        if (stall) begin
            held = o_data;
            i_frame = ~frm;
            i_frame_valid = 1'b1;
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                chk(o_valid && o_kind == 2'd0 && o_data == held,
                    "R9 word held under stall", o_data, held);
                chk(!o_frame_ready, "R10 no frame taken while busy", o_frame_ready, 0);
            end
            i_frame_valid = 1'b0;
            hold = 1'b0;
        end
        while (!o_frame_ready) @(negedge clk);
        chk(cap_n - base == n_exp, $sformatf("R1 R8 word count vec %0d", vi),
            cap_n - base, n_exp);
        for (int i = 0; i < n_exp && i < cap_n - base; i++) begin
            chk(cap_kind[base+i] == ek[i] && cap_data[base+i] == ed[i],
                $sformatf("%s vec %0d word %0d",
                          (ek[i] == 2'd0) ? "R3 R4 R5 header" :
                          (ek[i] == 2'd1) ? "R7 R8 size" : "R2 hit", vi, i),
                {cap_kind[base+i], cap_data[base+i]}, {ek[i], ed[i]});
        end
        bp_en = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog act=%0d exp=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [FR_W-1:0] frm;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!o_valid && o_frame_ready, "R10 reset state",
            {o_valid, o_frame_ready}, 2'b01);

        for (int vi = 0; vi < N_VEC; vi++) begin
            build_frame(VECS[vi], frm);
            run_frame(VECS[vi], frm, vi, 1'b0);
        end

        // R9: stall the header, offer a second frame, release and compare
        build_frame('{2'd0, 6'd3, 7'd9, 7'd30, 8'd2, 1'b0}, frm);
        run_frame('{2'd0, 6'd3, 7'd9, 7'd30, 8'd2, 1'b0}, frm, 20, 1'b1);

        // R6: empty policy-2 frames on back-to-back cycles
        @(negedge clk);
        base = cap_n;
        i_mode = 2'd2; i_thresh = 6'd5;
        for (int c = 0; c < N_CH; c++) i_frame[c*ADC_W +: ADC_W] = 6'd5;
        i_frame_valid = 1'b1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            chk(o_frame_ready && !o_valid, "R6 back-to-back empty frames",
                {o_frame_ready, o_valid}, 2'b10);
        end
        i_frame_valid = 1'b0;
        @(negedge clk);
        chk(cap_n == base, "R6 no words from empty frames", cap_n - base, 0);

        // R1: threshold reading equal is dropped, one above is kept (policy 0)
        build_frame('{2'd0, 6'd20, 7'd40, 7'd1, 8'd1, 1'b0}, frm);
        frm[41*ADC_W +: ADC_W] = 6'd20;
        run_frame('{2'd0, 6'd20, 7'd40, 7'd1, 8'd1, 1'b0}, frm, 21, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule